// File: doc/BRIEF.md
# Asynchronous Timer Register Update Bridge

This block sits between a fast bus clock domain and a slow, free-running timer clock such as a 32 kHz crystal. It owns the bus-side view of three timer registers: counter, compare and control. In asynchronous mode a bus write lands in a bus-side holding register and raises a busy flag for that register. The value is then handed to the timer domain with a toggle handshake, and the flag drops once the timer side has acknowledged the copy. Software polls the busy flags before it writes the same register again. A write made while the flag is still set is not protected, and neither is a change of the clock-select bit.

Reads do not all behave the same way. A read of the counter returns the live timer count. In asynchronous mode that count is a snapshot, carried across the domains by a second handshake so that the bus never samples a value that is still changing. A read of the compare or control register returns the bus-side holding copy.

A clock-select bit in the status register drives `async_sel`, which steers an external clock mux for the timer core. When the bit is zero the timer runs from the bus clock, writes take effect directly and the busy flags stay at zero. The timer core and its prescaler lie outside this block.

Top module: `async_tmr_bridge`

## Requirements
- R1: After reset, the status register reads 0, the compare and control holding registers read 0, and the `cmp_val` and `ctl_val` outputs are 0.
- R2: The register address map is 0 = counter, 1 = compare, 2 = control, 3 = status. Status bit 3 is the clock select, and a status write loads it from write-data bit 3. Bit 2 is counter busy, bit 1 is compare busy and bit 0 is control busy. All other status bits read 0, and `async_sel` equals the select bit.
- R3: With select = 1, a write to the counter, compare or control register while that register's busy flag is clear sets that register's busy flag from the next bus cycle on. The other busy flags are not changed.
- R4: A busy flag stays set until the timer domain has copied the value and the acknowledge has returned. After the flag clears, `cmp_val` or `ctl_val` holds the written value. For the counter, `cnt_load` has already pulsed for one timer cycle with `cnt_load_val` equal to the written value.
- R5: A read of the compare or control register returns the last written value at once, including while the transfer is still busy and the timer-domain output still holds the old value.
- R6: A read of the counter returns the live timer count. With select = 1 the value is a handshake-confirmed snapshot that trails the count by only a few timer cycles. With select = 0 it is the count itself.
- R7: With select = 0, a write reaches the timer-domain register on the next clock edge, and all busy flags stay at 0.
- R8: A second write to a register whose busy flag is set starts no new transfer. It updates the holding copy, the flag stays set, and the flag later clears through the original handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| tmr_clk | input | 1 | Timer-domain clock (output of the external mux steered by `async_sel`) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside each domain |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| async_sel | output | 1 | Clock select: 1 = timer runs from the crystal, 0 = timer runs from the bus clock |
| tmr_count | input | DW | Live count from the timer core (timer domain) |
| cnt_load | output | 1 | One-cycle timer-domain strobe to load the counter |
| cnt_load_val | output | DW | Value to load into the counter |
| cmp_val | output | DW | Compare value in the timer domain |
| ctl_val | output | DW | Control value in the timer domain |

## Verification
The bench builds the block with its defaults: DW = 8 and two synchronizer stages. It runs the crystal at a 61 ns period against the 5 ns bus clock. At that ratio one transfer keeps a busy flag set for dozens of bus cycles, so the bench can read a holding copy, re-write a busy register and sample the stale timer-domain output inside the window. The 8-bit width lets the live counter read be checked against a behavioural timer core with a small modular lag window. The bench also covers the same register set in bus-clock mode, where every result must appear without any busy window.

// File: rtl/atb_pkg.sv
`timescale 1ns/1ps
package atb_pkg;
  // register addresses
  localparam logic [1:0] A_CNT = 2'd0;
  localparam logic [1:0] A_CMP = 2'd1;
  localparam logic [1:0] A_CTL = 2'd2;
  localparam logic [1:0] A_STS = 2'd3;

  // status bit positions; channel index equals its busy bit
  localparam int ST_SEL = 3;
  localparam int CH_CTL = 0;
  localparam int CH_CMP = 1;
  localparam int CH_CNT = 2;
  localparam int NCH    = 3;

  function automatic logic [1:0] ch_addr(input int ch);
    if (ch == CH_CNT) return A_CNT;
    else if (ch == CH_CMP) return A_CMP;
    else return A_CTL;
  endfunction
endpackage

// File: rtl/atb_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer; with d tied high it forms a reset synchronizer.
module atb_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/atb_wr_chan.sv
`timescale 1ns/1ps
// One register write channel: holding copy, busy flag, toggle handshake.
module atb_wr_chan #(
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tclk,
  input  logic          trst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] tmp_o,
  output logic          busy_o,
  output logic [DW-1:0] val_o,
  output logic          upd_o
);
  // ---------------- bus domain ----------------
  logic [DW-1:0] tmp_q, tmp_d;
  logic          busy_q, busy_d;
  logic          req_q, req_d;
  logic          ack_s;

  always_comb begin
    tmp_d  = tmp_q;
    busy_d = busy_q;
    req_d  = req_q;
    if (wr) tmp_d = wdata;
    if (busy_q && (ack_s == req_q)) busy_d = 1'b0;
    if (wr && sel && !busy_q) begin
      req_d  = ~req_q;
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmp_q  <= '0;
      busy_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      tmp_q  <= tmp_d;
      busy_q <= busy_d;
      req_q  <= req_d;
    end
  end

  // ---------------- timer domain ----------------
  logic          req_s;
  logic          seen_q, seen_d;
  logic [DW-1:0] val_q, val_d;
  logic          upd_q, upd_d;

  atb_sync #(.STAGES(STAGES), .W(1)) u_req_sync (
    .clk(tclk), .rst_n(trst_n), .d(req_q), .q(req_s)
  );

  always_comb begin
    seen_d = seen_q;
    val_d  = val_q;
    upd_d  = 1'b0;
    if (sel) begin
      if (req_s != seen_q) begin
        seen_d = req_s;
        val_d  = tmp_q;
        upd_d  = 1'b1;
      end
    end else if (wr) begin
      val_d = wdata;
      upd_d = 1'b1;
    end
  end

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      seen_q <= 1'b0;
      val_q  <= '0;
      upd_q  <= 1'b0;
    end else begin
      seen_q <= seen_d;
      val_q  <= val_d;
      upd_q  <= upd_d;
    end
  end

  atb_sync #(.STAGES(STAGES), .W(1)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(seen_q), .q(ack_s)
  );

  assign tmp_o  = tmp_q;
  assign busy_o = busy_q;
  assign val_o  = val_q;
  assign upd_o  = upd_q;

  AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel && !busy_q) |=> busy_q); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (ack_s != req_q)) |=> busy_q); // R4
  AST_SYNC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && !busy_q) |=> !busy_q); // R7
  AST_REWRITE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && busy_q) |=> $stable(req_q)); // R8
  AST_VAL_WITH_UPD: assert property (@(posedge tclk) disable iff (!trst_n)
    !$stable(val_q) |-> upd_q); // R4
endmodule

// File: rtl/atb_cnt_rd.sv
`timescale 1ns/1ps
// Carries a stable snapshot of the live count into the bus domain.
module atb_cnt_rd #(
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tclk,
  input  logic          trst_n,
  input  logic [DW-1:0] count,
  output logic [DW-1:0] rd_o
);
  // timer domain: snapshot held until the bus side acknowledges
  logic [DW-1:0] snap_q, snap_d;
  logic          stog_q, stog_d;
  logic          ack_s;

  always_comb begin
    snap_d = snap_q;
    stog_d = stog_q;
    if (ack_s == stog_q) begin
      snap_d = count;
      stog_d = ~stog_q;
    end
  end

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      snap_q <= '0;
      stog_q <= 1'b0;
    end else begin
      snap_q <= snap_d;
      stog_q <= stog_d;
    end
  end

  // bus domain: capture when the toggle arrives
  logic          stog_s;
  logic          seen_q, seen_d;
  logic [DW-1:0] rd_q, rd_d;

  atb_sync #(.STAGES(STAGES), .W(1)) u_tog_sync (
    .clk(clk), .rst_n(rst_n), .d(stog_q), .q(stog_s)
  );

  always_comb begin
    seen_d = seen_q;
    rd_d   = rd_q;
    if (stog_s != seen_q) begin
      seen_d = stog_s;
      rd_d   = snap_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      seen_q <= seen_d;
      rd_q   <= rd_d;
    end
  end

  atb_sync #(.STAGES(STAGES), .W(1)) u_ack_sync (
    .clk(tclk), .rst_n(trst_n), .d(seen_q), .q(ack_s)
  );

  assign rd_o = rd_q;

  AST_SNAP_HOLD: assert property (@(posedge tclk) disable iff (!trst_n)
    (ack_s != stog_q) |=> $stable(snap_q)); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stog_s == seen_q) |=> $stable(rd_q)); // R6
endmodule

// File: rtl/async_tmr_bridge.sv
`timescale 1ns/1ps
module async_tmr_bridge
  import atb_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          tmr_clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          async_sel,
  input  logic [DW-1:0] tmr_count,
  output logic          cnt_load,
  output logic [DW-1:0] cnt_load_val,
  output logic [DW-1:0] cmp_val,
  output logic [DW-1:0] ctl_val
);
  // per-domain reset release
  logic brst_n, trst_n;

  atb_sync #(.STAGES(SYNC_STAGES), .W(1)) u_brst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(brst_n)
  );
  atb_sync #(.STAGES(SYNC_STAGES), .W(1)) u_trst (
    .clk(tmr_clk), .rst_n(rst_n), .d(1'b1), .q(trst_n)
  );

  // clock select bit
  logic sel_q, sel_d;
  logic sts_wr;

  assign sts_wr = bus_wr && (bus_addr == A_STS);

  always_comb begin
    sel_d = sel_q;
    if (sts_wr) sel_d = bus_wdata[ST_SEL];
  end

  always_ff @(posedge clk or negedge brst_n) begin
    if (!brst_n) sel_q <= 1'b0;
    else         sel_q <= sel_d;
  end

  // write channels
  logic [NCH-1:0] busy_v;
  logic [NCH-1:0] upd_v;
  logic [DW-1:0]  tmp_v [NCH];
  logic [DW-1:0]  val_v [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [1:0] CH_A = ch_addr(g);
    logic hit;
    assign hit = bus_wr && (bus_addr == CH_A);

    atb_wr_chan #(.DW(DW), .STAGES(SYNC_STAGES)) u_chan (
      .clk(clk), .rst_n(brst_n), .tclk(tmr_clk), .trst_n(trst_n),
      .sel(sel_q), .wr(hit), .wdata(bus_wdata),
      .tmp_o(tmp_v[g]), .busy_o(busy_v[g]),
      .val_o(val_v[g]), .upd_o(upd_v[g])
    );
  end

  // live count path
  logic [DW-1:0] cnt_snap;

  atb_cnt_rd #(.DW(DW), .STAGES(SYNC_STAGES)) u_cnt_rd (
    .clk(clk), .rst_n(brst_n), .tclk(tmr_clk), .trst_n(trst_n),
    .count(tmr_count), .rd_o(cnt_snap)
  );

  // read mux
  logic [DW-1:0] sts_word;

  always_comb begin
    sts_word              = '0;
    sts_word[ST_SEL]      = sel_q;
    sts_word[NCH-1:0]     = busy_v;
    case (bus_addr)
      A_CNT:   bus_rdata = sel_q ? cnt_snap : tmr_count;
      A_CMP:   bus_rdata = tmp_v[CH_CMP];
      A_CTL:   bus_rdata = tmp_v[CH_CTL];
      default: bus_rdata = sts_word;
    endcase
  end

  assign async_sel    = sel_q;
  assign cnt_load     = upd_v[CH_CNT];
  assign cnt_load_val = val_v[CH_CNT];
  assign cmp_val      = val_v[CH_CMP];
  assign ctl_val      = val_v[CH_CTL];

  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!brst_n)
    sts_wr |=> (async_sel == $past(bus_wdata[ST_SEL]))); // R2
  AST_SEL_KEEP: assert property (@(posedge clk) disable iff (!brst_n)
    !sts_wr |=> $stable(async_sel)); // R2
  AST_LOAD_PULSE: assert property (@(posedge tmr_clk) disable iff (!trst_n)
    cnt_load && async_sel |=> !cnt_load); // R4
endmodule

// File: tb/test_async_tmr_bridge.sv
`timescale 1ns/1ps
module test_async_tmr_bridge;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic xtal = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;
  always #30.5 xtal = ~xtal;

  logic [1:0]    bus_addr = 2'd0;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata, cnt_load_val, cmp_val, ctl_val;
  logic          async_sel, cnt_load, tmr_clk;
  logic [DW-1:0] tcnt = '0;
  logic [DW-1:0] last_ld = '0;

  assign tmr_clk = async_sel ? xtal : clk;

  // behavioural timer core
  always @(posedge tmr_clk) begin
    if (cnt_load) begin
      tcnt    <= cnt_load_val;
      last_ld <= cnt_load_val;
    end else begin
      tcnt <= tcnt + 1'b1;
    end
  end

  async_tmr_bridge #(.DW(DW), .SYNC_STAGES(2)) i_async_tmr_bridge (
    .clk(clk), .tmr_clk(tmr_clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .async_sel(async_sel), .tmr_count(tcnt),
    .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
    .cmp_val(cmp_val), .ctl_val(ctl_val)
  );

  // scoreboard: src 0 rdata range, 1 cmp_val, 2 ctl_val, 3 live count window, 4 last load
  typedef struct {
    int    src;
    int    lo;
    int    hi;
    string req;
  } exp_t;

  exp_t sb[$];
  bit   mon_go = 1'b0;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  always @(negedge clk) begin
    if (mon_go) begin
      exp_t e;
      int   act;
      bit   ok;
      e = sb.pop_front();
      mon_go = 1'b0;
      checks++;
      act = 0;
      ok  = 1'b0;
      case (e.src)
        0: act = int'(bus_rdata);
        1: act = int'(cmp_val);
        2: act = int'(ctl_val);
        3: act = int'(bus_rdata);
        default: act = int'(last_ld);
      endcase
      if (e.src == 3) begin
        e.hi = int'(tcnt);
        e.lo = (e.hi - 6) & 255;
        ok = (((e.hi - act) & 255) <= 6);
      end else begin
        ok = (act >= e.lo) && (act <= e.hi);
      end
      if (!ok) begin
        fails++;
        $display("FAIL %s: actual=%0h expected=%0h..%0h", e.req, act, e.lo, e.hi);
      end
    end
  end

  task automatic expect_item(input int src, input logic [1:0] a,
                             input int lo, input int hi, input string req);
    @(posedge clk); #1;
    bus_addr = a;
    sb.push_back('{src, lo, hi, req});
    mon_go = 1'b1;
    @(posedge clk);
  endtask

  task automatic expect_eq(input int src, input logic [1:0] a,
                           input int v, input string req);
    expect_item(src, a, v, v, req);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n;
    n = 0;
    @(posedge clk); #1;
    bus_addr = 2'd3;
    @(negedge clk);
    while (((bus_rdata & 8'h07) != 0) && (n < 5000)) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) begin
      checks++;
      fails++;
      $display("FAIL %s: busy stuck actual=%0h expected=0", req, bus_rdata & 8'h07);
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (6) @(posedge clk);

    // R1 reset state
    expect_eq(0, 2'd3, 8'h00, "R1 status");
    expect_eq(0, 2'd1, 8'h00, "R1 compare copy");
    expect_eq(1, 2'd1, 8'h00, "R1 cmp_val");
    expect_eq(2, 2'd2, 8'h00, "R1 ctl_val");

    // bus-clock mode (select = 0)
    wr(2'd1, 8'h5A);
    expect_eq(0, 2'd3, 8'h00, "R7 no busy after compare write");
    expect_eq(1, 2'd1, 8'h5A, "R7 cmp_val direct");
    wr(2'd2, 8'h33);
    expect_eq(2, 2'd2, 8'h33, "R7 ctl_val direct");
    expect_eq(0, 2'd2, 8'h33, "R5 control copy");
    wr(2'd0, 8'h40);
    expect_eq(4, 2'd0, 8'h40, "R7 counter load");
    expect_item(3, 2'd0, 0, 0, "R6 live count sync");

    // switch to crystal clock
    wr(2'd3, 8'h08);
    expect_eq(0, 2'd3, 8'h08, "R2 select bit");
    repeat (400) @(posedge clk);

    // compare transfer
    wr(2'd1, 8'hA5);
    expect_eq(0, 2'd3, 8'h0A, "R3 compare busy only");
    expect_eq(1, 2'd1, 8'h5A, "R5 cmp_val still old while busy");
    expect_eq(0, 2'd1, 8'hA5, "R5 compare copy while busy");
    wait_idle("R4 compare");
    expect_eq(1, 2'd1, 8'hA5, "R4 cmp_val after transfer");
    expect_eq(0, 2'd3, 8'h08, "R4 busy cleared");

    // control transfer
    wr(2'd2, 8'h96);
    expect_eq(0, 2'd3, 8'h09, "R3 control busy only");
    wait_idle("R4 control");
    expect_eq(2, 2'd2, 8'h96, "R4 ctl_val after transfer");

    // counter transfer
    wr(2'd0, 8'h80);
    expect_eq(0, 2'd3, 8'h0C, "R3 counter busy only");
    wait_idle("R4 counter");
    repeat (300) @(posedge clk);
    expect_eq(4, 2'd0, 8'h80, "R4 counter load value");
    expect_item(3, 2'd0, 0, 0, "R6 live count async");
    repeat (137) @(posedge clk);
    expect_item(3, 2'd0, 0, 0, "R6 live count async later");

    // rewrite while busy
    wr(2'd1, 8'h11);
    wr(2'd1, 8'h22);
    expect_eq(0, 2'd3, 8'h0A, "R8 busy kept on rewrite");
    expect_eq(0, 2'd1, 8'h22, "R8 copy updated");
    wait_idle("R8 clears");
    expect_eq(0, 2'd3, 8'h08, "R8 busy cleared");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule